// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block computes the product C = A x B, with A of shape M x K and B of shape K x N, on a square grid of multiply-accumulate cells. The default build uses M = 16, K = 16 and N = 4. Each grid row handles one index of the reduction dimension K, and each grid column handles one output row index m. The cell at row k and column m keeps A[m][k] in a stationary register. Operand elements B[k][j] enter row k at the left edge and hop one column to the right per cycle. Partial sums move one row down per cycle. Row 0 starts every sum from zero, and each finished C[m][j] leaves the bottom of column m together with a valid flag.

Weights are loaded through a downward shift path, one pulse per grid row. A start pulse then opens a run of a fixed length. The caller drives B with a skew: element B[k][j] goes onto row k during run cycle j+k. Run cycle 0 is the cycle right after the clock edge that samples start.

A small controller sequences the block through five states:
- IDLE: after reset; no weights are held.
- LOAD: counting weight shifts.
- READY: weights held; waiting for start.
- RUN: counting the run cycles.
- DONE: result complete; the done flag is high.

Its transitions are:
- IDLE→LOAD on a load pulse.
- LOAD→READY on the ROWS-th pulse.
- READY→LOAD on a load pulse. This has priority over start.
- READY→RUN on start.
- RUN→DONE after the last run cycle.
- DONE→LOAD on a load pulse.
- DONE→READY on restart.

Top module: `wsa_array`

## Requirements
- R1: After reset, done is low, every bit of c_vld is low, and the controller is in IDLE.
- R2: Each wt_load pulse outside RUN shifts every column's weights down one row, and row 0 takes wt_col. After ROWS pulses, row k holds the column value applied at pulse ROWS-1-k. Column m occupies wt_col bits [m*DW +: DW]. A start pulse before all ROWS pulses have been seen is ignored.
- R3: An operand applied on row k (op_dat bits [k*DW +: DW]) in run cycle t is used by column m in run cycle t+m.
- R4: Row 0 starts each partial sum at zero. Each cell adds its signed product A[m][k]*B[k][j] to the sum from the row above, in two's complement arithmetic on DW-bit operands and AW-bit sums.
- R5: C[m][j] appears on c_out bits [m*AW +: AW], with c_vld[m] high, in run cycle j+m+ROWS and in no other cycle of the run.
- R6: done rises in run cycle NVEC+COLS+ROWS-1, which is 35 by default and is one cycle after C[COLS-1][NVEC-1] leaves the array.
- R7: While in DONE, start pulses and operand inputs are ignored: done stays high and c_vld stays zero.
- R8: A restart pulse in DONE lowers done in the next cycle and rearms the array with the held weights. A full reload from DONE also rearms the array, with new weights.
- R9: Operand inputs applied outside RUN are ignored and raise no c_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_load | input | 1 | Shift one weight row into the grid |
| wt_col | input | COLS*DW | Per-column weight value entering row 0 |
| start | input | 1 | Begin a run (honoured in READY only) |
| restart | input | 1 | Rearm from DONE with the held weights |
| op_dat | input | ROWS*DW | Skewed operand per row |
| op_vld | input | ROWS | Operand valid per row |
| c_out | output | COLS*AW | Result element per column |
| c_vld | output | COLS | Result valid per column |
| done | output | 1 | Run finished |

## Verification
The bench builds the block with ROWS = 16, COLS = 16, NVEC = 4 and DW = 8, so AW = 20. With these values every one of the 64 results is compared in the exact cycle it should appear, and the 35-cycle run length can be checked. The extreme operands -128 and 127 drive the sums close to the accumulator range. An identity weight pattern exposes any mix-up in the row and column mapping. The same parameters also bring within reach the partial-load, ignored-start, restart and reload paths.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READY,
        ST_RUN,
        ST_DONE
    } wsa_state_t;

endpackage

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
    import wsa_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int LAST = 34
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wt_load,
    input  logic       start,
    input  logic       restart,
    output logic       wt_shift,
    output logic       run,
    output logic       done,
    output wsa_state_t st_o
);

    localparam int LDW = $clog2(ROWS + 1);
    localparam int RCW = $clog2(LAST + 1);

    wsa_state_t     st, nxt;
    logic [LDW-1:0] ld_cnt;
    logic [RCW-1:0] run_cnt;

    // next-state selection
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (wt_load) nxt = ST_LOAD;
            ST_LOAD:  if (wt_load && ld_cnt == LDW'(ROWS - 1)) nxt = ST_READY;
            ST_READY: if (wt_load) nxt = ST_LOAD;
                      else if (start) nxt = ST_RUN;
            ST_RUN:   if (run_cnt == RCW'(LAST)) nxt = ST_DONE;
            ST_DONE:  if (wt_load) nxt = ST_LOAD;
                      else if (restart) nxt = ST_READY;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ld_cnt  <= '0;
            run_cnt <= '0;
        end else begin
            st <= nxt;
            if (wt_shift)
                ld_cnt <= (st == ST_LOAD) ? ld_cnt + LDW'(1) : LDW'(1);
            if (st == ST_RUN)
                run_cnt <= run_cnt + RCW'(1);
            else
                run_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        wt_shift = wt_load && (st != ST_RUN);
        run      = (st == ST_RUN);
        done     = (st == ST_DONE);
        st_o     = st;
    end

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (run_cnt <= RCW'(LAST)));

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st) == ST_RUN));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !wt_load && !restart) |=> (st == ST_DONE));

    // R2
    no_early_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_LOAD) |=> (st != ST_RUN));

endmodule

// File: rtl/wsa_pe.sv
module wsa_pe #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_in,
    input  logic                 a_vld,
    input  logic signed [DW-1:0] w,
    input  logic signed [AW-1:0] ps_in,
    input  logic                 ps_vld_in,
    output logic signed [AW-1:0] ps_out,
    output logic                 ps_vld_out
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    always_comb begin
        prod     = a_in * w;
        prod_ext = {{(AW - PW){prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_out     <= '0;
            ps_vld_out <= 1'b0;
        end else begin
            ps_vld_out <= a_vld;
            ps_out     <= a_vld ? (ps_in + prod_ext) : '0;
        end
    end

    // R4
    sum_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld |-> ps_vld_in);

endmodule

// File: rtl/wsa_array.sv
module wsa_array
    import wsa_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int NVEC = 4,
    parameter int DW   = 8,
    parameter int AW   = 2 * DW + $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_load,
    input  logic [COLS*DW-1:0]   wt_col,
    input  logic                 start,
    input  logic                 restart,
    input  logic [ROWS*DW-1:0]   op_dat,
    input  logic [ROWS-1:0]      op_vld,
    output logic [COLS*AW-1:0]   c_out,
    output logic [COLS-1:0]      c_vld,
    output logic                 done
);

    localparam int LAST = (NVEC - 1) + (COLS - 1) + ROWS;

    logic       wt_shift;
    logic       run;
    wsa_state_t st;

    wsa_ctrl #(
        .ROWS (ROWS),
        .LAST (LAST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wt_load  (wt_load),
        .start    (start),
        .restart  (restart),
        .wt_shift (wt_shift),
        .run      (run),
        .done     (done),
        .st_o     (st)
    );

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        for (genvar m = 0; m < COLS; m++) begin : g_col
            logic signed [DW-1:0] a_cur;
            logic                 v_cur;
            logic signed [DW-1:0] w_cur;
            logic signed [AW-1:0] ps_cur;
            logic                 psv_cur;
            logic signed [AW-1:0] ps_above;
            logic                 psv_above;

            // operand hop: one register per column step
            if (m == 0) begin : g_edge
                assign a_cur = op_dat[k*DW +: DW];
                assign v_cur = op_vld[k] & run;
            end else begin : g_hop
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        a_cur <= '0;
                        v_cur <= 1'b0;
                    end else begin
                        a_cur <= g_row[k].g_col[m-1].a_cur;
                        v_cur <= g_row[k].g_col[m-1].v_cur;
                    end
                end
            end

            // stationary weight with downward shift path
            if (k == 0) begin : g_wtop
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        w_cur <= '0;
                    else if (wt_shift) w_cur <= wt_col[m*DW +: DW];
                end
                assign ps_above  = '0;
                assign psv_above = v_cur;
            end else begin : g_wchain
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        w_cur <= '0;
                    else if (wt_shift) w_cur <= g_row[k-1].g_col[m].w_cur;
                end
                assign ps_above  = g_row[k-1].g_col[m].ps_cur;
                assign psv_above = g_row[k-1].g_col[m].psv_cur;
            end

            wsa_pe #(
                .DW (DW),
                .AW (AW)
            ) u_pe (
                .clk        (clk),
                .rst_n      (rst_n),
                .a_in       (a_cur),
                .a_vld      (v_cur),
                .w          (w_cur),
                .ps_in      (ps_above),
                .ps_vld_in  (psv_above),
                .ps_out     (ps_cur),
                .ps_vld_out (psv_cur)
            );

            if (k == ROWS - 1) begin : g_bottom
                assign c_out[m*AW +: AW] = ps_cur;
                assign c_vld[m]          = psv_cur;
            end
        end
    end

    // R5
    vld_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|c_vld) |-> (st == ST_RUN));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c_vld == '0));

endmodule

// File: tb/wsa_array_test.sv
module wsa_array_test;

    localparam int CLK_P = 10;
    localparam int ROWS  = 16;
    localparam int COLS  = 16;
    localparam int NVEC  = 4;
    localparam int DW    = 8;
    localparam int AW    = 2 * DW + $clog2(ROWS);
    localparam int LAST  = (NVEC - 1) + (COLS - 1) + ROWS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wt_load = 1'b0;
    logic [COLS*DW-1:0]  wt_col = '0;
    logic                start = 1'b0;
    logic                restart = 1'b0;
    logic [ROWS*DW-1:0]  op_dat = '0;
    logic [ROWS-1:0]     op_vld = '0;
    logic [COLS*AW-1:0]  c_out;
    logic [COLS-1:0]     c_vld;
    logic                done;

    int n_chk = 0;
    int n_bad = 0;
    int A [COLS][ROWS];
    int B [ROWS][NVEC];

    wsa_array #(
        .ROWS (ROWS), .COLS (COLS), .NVEC (NVEC), .DW (DW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .wt_load (wt_load), .wt_col (wt_col),
        .start (start), .restart (restart), .op_dat (op_dat), .op_vld (op_vld),
        .c_out (c_out), .c_vld (c_vld), .done (done)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        wt_load = 0; start = 0; restart = 0; op_vld = '0; op_dat = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic load_weights(int pulses);
        for (int t = 0; t < pulses; t++) begin
            wt_load = 1;
            for (int m = 0; m < COLS; m++)
                wt_col[m*DW +: DW] = DW'(A[m][ROWS-1-t]);
            @(negedge clk);
        end
        wt_load = 0;
    endtask

    // drive all operands valid with junk, check nothing emerges
    task automatic quiet_watch(int n, int exp_done, string tag);
        for (int t = 0; t < n; t++) begin
            op_vld = '1;
            op_dat = {ROWS{8'h3C}};
            @(negedge clk);
            chk({tag, " c_vld"}, int'(c_vld), 0);
            chk({tag, " done"}, int'(done), exp_done);
        end
        op_vld = '0;
    endtask

    // R3 R4 R5 R6: full run with per-cycle comparison
    task automatic run_product(string tag);
        int expc [COLS][NVEC];
        for (int m = 0; m < COLS; m++)
            for (int j = 0; j < NVEC; j++) begin
                expc[m][j] = 0;
                for (int k = 0; k < ROWS; k++) expc[m][j] += A[m][k] * B[k][j];
            end
        start = 1;
        @(negedge clk);
        start = 0;
        for (int t = 0; t < LAST + 5; t++) begin
            // sample outputs visible in run cycle t
            for (int m = 0; m < COLS; m++) begin
                int j;
                j = t - ROWS - m;
                if (j >= 0 && j < NVEC) begin
                    chk({tag, " R5 vld"}, int'(c_vld[m]), 1);
                    chk({tag, " R4/R5 value"}, int'($signed(c_out[m*AW +: AW])), expc[m][j]);
                end else begin
                    chk({tag, " R5 idle vld"}, int'(c_vld[m]), 0);
                end
            end
            chk({tag, " R6 done"}, int'(done), (t >= LAST + 1) ? 1 : 0);
            // drive skewed operands for run cycle t (R3)
            for (int k = 0; k < ROWS; k++) begin
                int j;
                j = t - k;
                if (j >= 0 && j < NVEC) begin
                    op_vld[k] = 1;
                    op_dat[k*DW +: DW] = DW'(B[k][j]);
                end else begin
                    op_vld[k] = 0;
                    op_dat[k*DW +: DW] = 8'hA5;
                end
            end
            @(negedge clk);
        end
        op_vld = '0;
    endtask

    task automatic fill_pattern(int seed, bit extreme);
        int s;
        s = seed;
        for (int m = 0; m < COLS; m++)
            for (int k = 0; k < ROWS; k++) begin
                s = (s * 1103515245 + 12345) & 32'h7fffffff;
                A[m][k] = extreme ? (((s >> 7) & 1) ? 127 : -128) : ((s >> 9) % 23) - 11;
            end
        for (int k = 0; k < ROWS; k++)
            for (int j = 0; j < NVEC; j++) begin
                s = (s * 1103515245 + 12345) & 32'h7fffffff;
                B[k][j] = extreme ? (((s >> 5) & 1) ? -128 : 127) : ((s >> 9) % 31) - 15;
            end
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 done", int'(done), 0);
        chk("R1 c_vld", int'(c_vld), 0);
    endtask

    task automatic test_start_before_load();
        do_reset();
        start = 1; @(negedge clk); start = 0;
        quiet_watch(40, 0, "R2 no weights");
        fill_pattern(7, 0);
        load_weights(8);
        start = 1; @(negedge clk); start = 0;
        quiet_watch(40, 0, "R2 partial load");
    endtask

    task automatic test_basic();
        do_reset();
        fill_pattern(11, 0);
        load_weights(ROWS);
        run_product("basic R2 R3");
    endtask

    task automatic test_done_ignores();
        start = 1; @(negedge clk); start = 0;
        quiet_watch(40, 1, "R7 start in done");
    endtask

    task automatic test_restart();
        restart = 1; @(negedge clk); restart = 0;
        chk("R8 done after restart", int'(done), 0);
        run_product("R8 rerun");
    endtask

    task automatic test_reload_extreme();
        fill_pattern(23, 1);
        load_weights(ROWS);
        chk("R8 done after reload", int'(done), 0);
        run_product("R8 reload extreme R4");
    endtask

    task automatic test_identity_gate();
        do_reset();
        fill_pattern(5, 0);
        for (int m = 0; m < COLS; m++)
            for (int k = 0; k < ROWS; k++) A[m][k] = (m == k) ? 1 : 0;
        load_weights(ROWS);
        quiet_watch(20, 0, "R9 operands in ready");
        run_product("R9 identity R3");
    endtask

    initial begin
        test_reset();
        test_start_before_load();
        test_basic();
        test_done_ignores();
        test_restart();
        test_reload_extreme();
        test_identity_gate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule